// File: doc/BRIEF.md
# SCL-Edge Anchored Bus Disturbance Timer

This block sits passively on an I2C bus whose clock is driven by some other master, the master under test. Once armed, it waits for that master's first SCL falling edge. From that edge it runs one timed action, chosen by a mode input.

In pull mode it asserts an open-drain SDA pull-down for a programmed number of microseconds. This corrupts the address the other master is sending, so that master should detect lost arbitration. In trigger mode it waits the programmed number of microseconds after the edge and then emits a single-cycle fault-trigger pulse.

A prescaler divides the system clock into microsecond ticks. Programmed values above a parameterised ceiling (100 ms by default) are clamped to it. The block never drives SCL. After each action it returns to idle and must be armed again.

All control pins are plain levels or pulses sampled on the rising clock edge. There is no data stream, and so there is no valid/ready handshake and no back-pressure. An abort input cancels an armed or running action at any time.

Top module: `scl_disturb_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sda_pull_o`, `trig_o` and `busy_o` are all low.
- R2: A high `arm_i` while idle (and without `abort_i`) raises `busy_o` at the next clock edge. `mode_i` and `dur_us_i` are captured in that cycle, and later changes to them have no effect on the armed action.
- R3: `arm_i` while `busy_o` is high is ignored: the mode and duration captured earlier stay in force.
- R4: While armed, nothing happens until `scl_i` falls. A rising or steady `scl_i` starts nothing. The action begins at the third rising clock edge after `scl_i` goes low, because of two synchroniser flops and one edge register.
- R5: In pull mode with a duration D > 0, `sda_pull_o` goes high at that third edge and stays high for exactly D*CLK_PER_US cycles. `sda_pull_o` and `busy_o` then fall on the same edge.
- R6: A duration above MAX_US is treated as exactly MAX_US.
- R7: In trigger mode with D > 0, `trig_o` is high for exactly one cycle, D*CLK_PER_US cycles after the third edge. `busy_o` falls on the same edge that `trig_o` rises.
- R8: In trigger mode with D = 0, the trigger pulse appears at the third edge itself.
- R9: In pull mode with D = 0, SDA is never pulled, and the block returns to idle at the third edge.
- R10: A high `abort_i` clears `sda_pull_o`, `trig_o` and `busy_o` at the next edge, from any state. Abort wins over a simultaneous `arm_i` and over an action completing in the same cycle.
- R11: Mode encoding: `mode_i` = 0 selects the SDA pull, and `mode_i` = 1 selects the delayed trigger.
- R12: After an action completes, later SCL falling edges do nothing until the block is armed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line (asynchronous) |
| mode_i | input | 1 | 0 = SDA pull, 1 = delayed trigger |
| dur_us_i | input | DUR_W | Pull length or trigger delay, in microseconds |
| arm_i | input | 1 | Arm request, honoured only when idle |
| abort_i | input | 1 | Cancel any armed or running action |
| sda_pull_o | output | 1 | Open-drain SDA pull-down enable |
| trig_o | output | 1 | One-cycle fault-trigger pulse |
| busy_o | output | 1 | High from arm until the action ends |

## Verification
Abort and completion can land in the same cycle. The bench provokes this by raising `abort_i` in the very cycle whose microsecond tick would fire the trigger, and then requires that no pulse ever appears and that `busy_o` drops. Arm and abort can also coincide while idle. Here abort must win, leaving `busy_o` low, and a following SCL fall must produce nothing.

// File: rtl/sdt_pkg.sv
`timescale 1ns/100ps
package sdt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } sdt_state_e;

  typedef enum logic {
    MODE_PULL = 1'b0,
    MODE_TRIG = 1'b1
  } sdt_mode_e;
endpackage

// File: rtl/sdt_scl_edge.sv
`timescale 1ns/100ps
module sdt_scl_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  output logic fall_o
);
  // sh[0..SYNC_STAGES-1] synchroniser, sh[SYNC_STAGES] previous sample
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[SYNC_STAGES-1:0], scl_i};
  end

  assign fall_o = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];

  // R4
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/sdt_us_tick.sv
`timescale 1ns/100ps
module sdt_us_tick #(
  parameter int CLK_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt;

  assign tick_o = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr_i)   cnt <= '0;
    else if (tick_o)  cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/sdt_dur_counter.sv
`timescale 1ns/100ps
module sdt_dur_counter #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         tick_i,
  output logic         done_o
);
  logic [W-1:0] rem;

  assign done_o = tick_i && (rem == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rem <= '0;
    else if (clr_i)                 rem <= '0;
    else if (load_i)                rem <= val_i;
    else if (tick_i && rem != '0)   rem <= rem - 1'b1;
  end

  // R5
  rem_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> rem <= $past(rem));
endmodule

// File: rtl/scl_disturb_timer.sv
`timescale 1ns/100ps
module scl_disturb_timer
  import sdt_pkg::*;
#(
  parameter int CLK_PER_US = 200,
  parameter int MAX_US     = 100000,
  parameter int DUR_W      = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             mode_i,
  input  logic [DUR_W-1:0] dur_us_i,
  input  logic             arm_i,
  input  logic             abort_i,
  output logic             sda_pull_o,
  output logic             trig_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(MAX_US + 1);

  sdt_state_e       state;
  sdt_mode_e        mode_q;
  logic [CNT_W-1:0] dur_q;
  logic [CNT_W-1:0] dur_clamp;
  logic             pull_q, trig_q;
  logic             scl_fall, us_tick, run_done, start;

  assign dur_clamp = (dur_us_i > DUR_W'(MAX_US)) ? CNT_W'(MAX_US) : CNT_W'(dur_us_i);
  assign start     = (state == ST_ARMED) && scl_fall && !abort_i;

  sdt_scl_edge #(.SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .fall_o(scl_fall)
  );

  sdt_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr_i(start), .tick_o(us_tick)
  );

  sdt_dur_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(abort_i), .load_i(start), .val_i(dur_q),
    .tick_i(us_tick && state == ST_RUN), .done_o(run_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= MODE_PULL;
      dur_q  <= '0;
      pull_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      if (abort_i) begin
        state  <= ST_IDLE;
        pull_q <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: if (arm_i) begin
            state  <= ST_ARMED;
            mode_q <= sdt_mode_e'(mode_i);
            dur_q  <= dur_clamp;
          end
          ST_ARMED: if (scl_fall) begin
            if (dur_q == '0) begin
              state  <= ST_IDLE;
              trig_q <= (mode_q == MODE_TRIG);
            end else begin
              state  <= ST_RUN;
              pull_q <= (mode_q == MODE_PULL);
            end
          end
          ST_RUN: if (run_done) begin
            state  <= ST_IDLE;
            pull_q <= 1'b0;
            trig_q <= (mode_q == MODE_TRIG);
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign trig_o     = trig_q;
  assign busy_o     = (state != ST_IDLE);

  // R10
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !busy_o && !sda_pull_o && !trig_o);
  // R7
  trig_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> !busy_o && $past(busy_o));
  // R7
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);
  // R5
  pull_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> busy_o && mode_q == MODE_PULL);
  // R2
  arm_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && arm_i && !abort_i |=> busy_o);
  // R3
  arm_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !abort_i |=> $stable(mode_q) && $stable(dur_q));
  // R6
  dur_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dur_q <= CNT_W'(MAX_US));
endmodule

// File: tb/scl_disturb_timer_tb.sv
`timescale 1ns/100ps
module scl_disturb_timer_tb;
  localparam int P    = 4;
  localparam int MAXU = 20;
  localparam int DW   = 17;
  localparam int NV   = 7;
  localparam int V_MODE[NV] = '{0, 0, 1, 1, 0, 0, 1};
  localparam int V_DUR [NV] = '{3, 1, 2, 0, 0, 25, 50};
  localparam int V_EFF [NV] = '{3, 1, 2, 0, 0, 20, 20};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, mode = 1'b0, arm = 1'b0, abort = 1'b0;
  logic [DW-1:0] dur = '0;
  logic sda_pull, trig, busy;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  scl_disturb_timer #(.CLK_PER_US(P), .MAX_US(MAXU), .DUR_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .mode_i(mode), .dur_us_i(dur),
    .arm_i(arm), .abort_i(abort), .sda_pull_o(sda_pull), .trig_o(trig), .busy_o(busy)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, int'({busy, sda_pull, trig}), 0);
    end
  endtask

  task automatic arm_op(int m, int d);
    @(negedge clk); arm = 1'b1; mode = m[0]; dur = DW'(d);
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic run_op(int m, int d, int eff);
    int len = eff * P;
    string t = (eff != d) ? "R6 " : "";
    arm_op(m, d);
    chk({t, "R2 busy after arm"}, int'(busy), 1);
    mode = ~mode; dur = DW'(7);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R4 no action before fall", int'({sda_pull, trig}), 0);
    end
    scl = 1'b0;
    for (int k = 1; k <= len + 5; k++) begin
      @(negedge clk);
      chk({t, "R5 R9 R11 pull"}, int'(sda_pull), int'(m == 0 && k >= 3 && k < 3 + len));
      chk({t, "R7 R8 R11 trig"}, int'(trig), int'(m == 1 && k == 3 + len));
      chk({t, "R5 R7 busy"}, int'(busy), int'(k < 3 + len));
    end
    scl = 1'b1;
    repeat (4) @(negedge clk);
    scl = 1'b0;
    quiet("R12 no rearm", 6);
    scl = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 in reset", int'({busy, sda_pull, trig}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", int'({busy, sda_pull, trig}), 0);
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) run_op(V_MODE[v], V_DUR[v], V_EFF[v]);

    // R3 second arm while busy ignored
    arm_op(0, 2);
    @(negedge clk); arm = 1'b1; mode = 1'b1; dur = DW'(0);
    @(negedge clk); arm = 1'b0;
    scl = 1'b0;
    for (int k = 1; k <= 2 * P + 4; k++) begin
      @(negedge clk);
      chk("R3 pull kept", int'(sda_pull), int'(k >= 3 && k < 3 + 2 * P));
      chk("R3 no trig", int'(trig), 0);
    end
    scl = 1'b1;
    repeat (4) @(negedge clk);

    // R4 rising SCL does not start the action
    scl = 1'b0;
    repeat (4) @(negedge clk);
    arm_op(0, 3);
    scl = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R4 rise ignored pull", int'(sda_pull), 0);
      chk("R4 rise ignored busy", int'(busy), 1);
    end
    scl = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 fall starts pull", int'(sda_pull), 1);
    // R10 abort while pulling
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R10 abort releases", int'({busy, sda_pull, trig}), 0);
    quiet("R10 stays idle", 4);
    scl = 1'b1;
    repeat (4) @(negedge clk);

    // R10 abort in the completing cycle of a trigger
    arm_op(1, 1);
    scl = 1'b0;
    for (int k = 1; k <= 3 + P - 1; k++) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R10 abort beats trigger", int'(trig), 0);
    chk("R10 abort busy", int'(busy), 0);
    quiet("R10 no late trig", 4);
    scl = 1'b1;
    repeat (4) @(negedge clk);

    // R10 arm and abort together while idle
    @(negedge clk); arm = 1'b1; abort = 1'b1; mode = 1'b0; dur = DW'(2);
    @(negedge clk); arm = 1'b0; abort = 1'b0;
    chk("R10 abort beats arm", int'(busy), 0);
    scl = 1'b0;
    quiet("R10 nothing armed", 6);
    scl = 1'b1;
    repeat (4) @(negedge clk);

    // R10 abort while armed
    arm_op(1, 0);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R10 abort armed", int'(busy), 0);
    scl = 1'b0;
    quiet("R10 disarmed", 6);
    scl = 1'b1;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule